// File: doc/BRIEF.md
# Interrupt entry sequencer

This block decides whether a pending interrupt level may be taken and, when it may, produces the architectural state update for entry into the handler. The core presents the pending level, the current program counter, the status word, and the raised and enabled interrupt bit vectors, then pulses a take strobe. The block answers on the next clock with a one-cycle pulse. That pulse carries the new program counter, the write enables and write data for the per-level save registers, the status word, the cause register, and a taken flag.

Levels above 1 enter a dedicated handler for each level. The program counter and the status word are saved for that level, and the status level field is raised to the level being entered. Level 1 is folded into the general exception path. It records a fixed cause code and becomes a user, kernel or double exception, chosen from the status mode bits. A double exception saves its return address either to a dedicated register or, when the build has none, to the level-1 save register.

Status word fields: bits [3:0] hold the current interrupt level, bit 4 is the exception-mode bit and bit 5 is the user-mode bit. Interrupt bit i belongs to level (i mod NLEVEL)+1.

The control is a state register with five states:
- ST_IDLE: no entry.
- ST_HIGH: high-level entry.
- ST_USER: user exception.
- ST_KERNEL: kernel exception.
- ST_DOUBLE: double exception.

From any state, an accepted take moves the register to the state for its entry kind. Any other cycle moves it to ST_IDLE, so every entry state lasts exactly one cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: During and after reset, taken_o and every write enable are low until an accepted take.
- R2: A take is accepted only if the pending level is above status bits [3:0], is at most NLEVEL, and at least one interrupt bit mapped to that level is both raised and enabled. Otherwise no output changes from its idle value.
- R3: On an accepted level L>1, epc_we_o and eps_we_o each assert only bit L-1. save_pc_o carries the PC and save_ps_o carries the status word present at the take.
- R4: On an accepted level L>1, ps_o equals the old status word with bits [3:0] set to L and bit 4 set, with ps_we_o high.
- R5: On an accepted level L>1, pc_o is VEC_BASE + L*VEC_STRIDE with pc_we_o high.
- R6: On an accepted level 1, cause_we_o is high with cause_o = CAUSE_L1, and eps_we_o stays zero.
- R7: On an accepted level 1 with status bit 4 set, the entry is a double exception with pc_o = VEC_BASE + DBL_OFF. The PC is saved through depc_we_o when HAS_DEPC is 1, and through epc_we_o bit 0 otherwise.
- R8: On an accepted level 1 with status bit 4 clear, epc_we_o bit 0 saves the PC. pc_o is VEC_BASE + USER_OFF if status bit 5 is set, and VEC_BASE + KERN_OFF otherwise.
- R9: On an accepted level 1, ps_o equals the old status word with bit 4 set and every other bit unchanged.
- R10: Outputs appear in the cycle after the clock edge that samples the take, and last exactly one cycle.
- R11: With take_i low, the next cycle shows taken_o low and all write enables low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| take_i | input | 1 | Take strobe for the pending level |
| pend_lvl_i | input | LW | Pending interrupt level |
| pc_i | input | XLEN | Current program counter |
| ps_i | input | PSW | Current status word |
| int_set_i | input | NINT | Raised interrupt bits |
| int_en_i | input | NINT | Enabled interrupt bits |
| taken_o | output | 1 | Entry performed |
| pc_we_o | output | 1 | Program counter redirect |
| pc_o | output | XLEN | New program counter |
| epc_we_o | output | NLEVEL | Per-level saved-PC write enables, bit k is level k+1 |
| eps_we_o | output | NLEVEL | Per-level saved-status write enables, bit k is level k+1 |
| depc_we_o | output | 1 | Double-exception PC register write |
| save_pc_o | output | XLEN | Data for saved-PC writes |
| save_ps_o | output | PSW | Data for saved-status writes |
| ps_we_o | output | 1 | Status word write |
| ps_o | output | PSW | New status word |
| cause_we_o | output | 1 | Cause register write |
| cause_o | output | CAUSE_W | Cause code |

## Verification
The bench sweeps every pending level, including 0 and levels beyond NLEVEL, against every current level, every combination of the two mode bits and several raised/enabled patterns, each with the strobe high and low.

It targets four kinds of corner case:
- A pending level equal to the current level, where an off-by-one comparison would take an interrupt that must be masked.
- Raised bits that belong to another level, which a design ignoring the level mapping would accept.
- Level 1 with the exception-mode bit set, where a design that skipped the double path would overwrite the level-1 save register or pick the wrong vector.
- The high-level status update, where a faulty mask would corrupt the upper status bits.

A second instance built without the dedicated double register confirms that the save falls back to the level-1 register.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_USER,
        ST_KERNEL,
        ST_DOUBLE
    } entry_e;

    localparam int PS_LVL_W  = 4;
    localparam int PS_EXCM_B = 4;
    localparam int PS_UM_B   = 5;
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int NLEVEL = 3,
    parameter int NINT   = 8,
    parameter int LW     = 3
) (
    input  logic [LW-1:0]   lvl_i,
    input  logic [3:0]      cur_lvl_i,
    input  logic [NINT-1:0] set_i,
    input  logic [NINT-1:0] en_i,
    output logic            accept_o
);
    logic [NINT-1:0] hit;
    logic [7:0]      lx;
    logic [7:0]      cx;

    for (genvar i = 0; i < NINT; i++) begin : g_bit
        localparam int BIT_LVL = (i % NLEVEL) + 1;
        assign hit[i] = set_i[i] & en_i[i] & (lvl_i == LW'(BIT_LVL));
    end

    assign lx = 8'(lvl_i);
    assign cx = 8'(cur_lvl_i);
    assign accept_o = (|hit) && (lx > cx) && (lx <= 8'(NLEVEL));
endmodule

// File: rtl/irq_classify.sv
module irq_classify
    import irq_seq_pkg::*;
#(
    parameter int LW = 3
) (
    input  logic [LW-1:0] lvl_i,
    input  logic          excm_i,
    input  logic          um_i,
    output entry_e        kind_o
);
    always_comb begin
        if (lvl_i > LW'(1))   kind_o = ST_HIGH;
        else if (excm_i)      kind_o = ST_DOUBLE;
        else if (um_i)        kind_o = ST_USER;
        else                  kind_o = ST_KERNEL;
    end
endmodule

// File: rtl/irq_vector.sv
module irq_vector
    import irq_seq_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              NLEVEL     = 3,
    parameter int              LW         = 3,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'h4000_0000,
    parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0100,
    parameter logic [XLEN-1:0] USER_OFF   = 32'h0000_0040,
    parameter logic [XLEN-1:0] KERN_OFF   = 32'h0000_0080,
    parameter logic [XLEN-1:0] DBL_OFF    = 32'h0000_00C0
) (
    input  entry_e          kind_i,
    input  logic [LW-1:0]   lvl_i,
    output logic [XLEN-1:0] vec_o
);
    logic [XLEN-1:0] lvl_vec [NLEVEL+1];

    for (genvar g = 0; g <= NLEVEL; g++) begin : g_lvl
        assign lvl_vec[g] = VEC_BASE + XLEN'(g) * VEC_STRIDE;
    end

    always_comb begin
        vec_o = VEC_BASE;
        unique case (kind_i)
            ST_HIGH: begin
                for (int k = 0; k <= NLEVEL; k++)
                    if (int'(lvl_i) == k) vec_o = lvl_vec[k];
            end
            ST_USER:   vec_o = VEC_BASE + USER_OFF;
            ST_KERNEL: vec_o = VEC_BASE + KERN_OFF;
            ST_DOUBLE: vec_o = VEC_BASE + DBL_OFF;
            ST_IDLE:   vec_o = VEC_BASE;
            default:   vec_o = VEC_BASE;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int              NLEVEL     = 3,
    parameter int              NINT       = 8,
    parameter int              XLEN       = 32,
    parameter int              PSW        = 16,
    parameter int              CAUSE_W    = 6,
    parameter logic [5:0]      CAUSE_L1   = 6'd4,
    parameter bit              HAS_DEPC   = 1'b1,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'h4000_0000,
    parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0100,
    parameter logic [XLEN-1:0] USER_OFF   = 32'h0000_0040,
    parameter logic [XLEN-1:0] KERN_OFF   = 32'h0000_0080,
    parameter logic [XLEN-1:0] DBL_OFF    = 32'h0000_00C0,
    localparam int             LW         = $clog2(NLEVEL + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [LW-1:0]      pend_lvl_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [PSW-1:0]     ps_i,
    input  logic [NINT-1:0]    int_set_i,
    input  logic [NINT-1:0]    int_en_i,
    output logic               taken_o,
    output logic               pc_we_o,
    output logic [XLEN-1:0]    pc_o,
    output logic [NLEVEL-1:0]  epc_we_o,
    output logic [NLEVEL-1:0]  eps_we_o,
    output logic               depc_we_o,
    output logic [XLEN-1:0]    save_pc_o,
    output logic [PSW-1:0]     save_ps_o,
    output logic               ps_we_o,
    output logic [PSW-1:0]     ps_o,
    output logic               cause_we_o,
    output logic [CAUSE_W-1:0] cause_o
);
    entry_e          state_q, state_d, kind_w;
    logic            accept_w;
    logic [LW-1:0]   lvl_q;
    logic [XLEN-1:0] pc_q;
    logic [PSW-1:0]  ps_q;
    logic [XLEN-1:0] vec_w;

    irq_gate #(.NLEVEL(NLEVEL), .NINT(NINT), .LW(LW)) u_gate (
        .lvl_i     (pend_lvl_i),
        .cur_lvl_i (ps_i[PS_LVL_W-1:0]),
        .set_i     (int_set_i),
        .en_i      (int_en_i),
        .accept_o  (accept_w)
    );

    irq_classify #(.LW(LW)) u_class (
        .lvl_i  (pend_lvl_i),
        .excm_i (ps_i[PS_EXCM_B]),
        .um_i   (ps_i[PS_UM_B]),
        .kind_o (kind_w)
    );

    irq_vector #(
        .XLEN(XLEN), .NLEVEL(NLEVEL), .LW(LW), .VEC_BASE(VEC_BASE),
        .VEC_STRIDE(VEC_STRIDE), .USER_OFF(USER_OFF), .KERN_OFF(KERN_OFF),
        .DBL_OFF(DBL_OFF)
    ) u_vec (
        .kind_i (state_q),
        .lvl_i  (lvl_q),
        .vec_o  (vec_w)
    );

    // next-state: every state leaves after one cycle
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_HIGH, ST_USER, ST_KERNEL, ST_DOUBLE:
                if (take_i && accept_w) state_d = kind_w;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            pc_q    <= '0;
            ps_q    <= '0;
        end else begin
            state_q <= state_d;
            if (take_i && accept_w) begin
                lvl_q <= pend_lvl_i;
                pc_q  <= pc_i;
                ps_q  <= ps_i;
            end
        end
    end

    always_comb begin
        taken_o    = 1'b0;
        pc_we_o    = 1'b0;
        pc_o       = vec_w;
        epc_we_o   = '0;
        eps_we_o   = '0;
        depc_we_o  = 1'b0;
        save_pc_o  = pc_q;
        save_ps_o  = ps_q;
        ps_we_o    = 1'b0;
        ps_o       = ps_q;
        cause_we_o = 1'b0;
        cause_o    = CAUSE_W'(CAUSE_L1);
        unique case (state_q)
            ST_IDLE: ;
            ST_HIGH: begin
                taken_o = 1'b1;
                pc_we_o = 1'b1;
                ps_we_o = 1'b1;
                ps_o[PS_LVL_W-1:0] = PS_LVL_W'(lvl_q);
                ps_o[PS_EXCM_B]    = 1'b1;
                for (int k = 0; k < NLEVEL; k++)
                    if (int'(lvl_q) == k + 1) begin
                        epc_we_o[k] = 1'b1;
                        eps_we_o[k] = 1'b1;
                    end
            end
            ST_USER, ST_KERNEL: begin
                taken_o         = 1'b1;
                pc_we_o         = 1'b1;
                ps_we_o         = 1'b1;
                ps_o[PS_EXCM_B] = 1'b1;
                cause_we_o      = 1'b1;
                epc_we_o[0]     = 1'b1;
            end
            ST_DOUBLE: begin
                taken_o         = 1'b1;
                pc_we_o         = 1'b1;
                ps_we_o         = 1'b1;
                ps_o[PS_EXCM_B] = 1'b1;
                cause_we_o      = 1'b1;
                if (HAS_DEPC) depc_we_o   = 1'b1;
                else          epc_we_o[0] = 1'b1;
            end
            default: ;
        endcase
    end

    // R10
    taken_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> $past(take_i));
    // R3
    one_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(epc_we_o) && $onehot0(eps_we_o));
    // R4
    excm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> ps_o[PS_EXCM_B]);
    // R4
    level_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eps_we_o != '0) |-> (ps_o[PS_LVL_W-1:0] > save_ps_o[PS_LVL_W-1:0]));
    // R6
    l1_no_eps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_we_o |-> (eps_we_o == '0));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> (!pc_we_o && !ps_we_o && !depc_we_o && !cause_we_o && epc_we_o == '0));
    // R7
    single_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depc_we_o |-> (epc_we_o == '0));
endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
    localparam int NL = 3;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        take;
    logic [2:0]  lvl;
    logic [31:0] pc;
    logic [15:0] ps;
    logic [7:0]  iset, ien;

    logic        taken, pc_we, depc_we, ps_we, cause_we;
    logic [31:0] pc_o, spc;
    logic [2:0]  epc_we, eps_we;
    logic [15:0] sps, ps_o;
    logic [5:0]  cause;

    logic        n_taken, n_pc_we, n_depc_we, n_ps_we, n_cause_we;
    logic [31:0] n_pc_o, n_spc;
    logic [2:0]  n_epc_we, n_eps_we;
    logic [15:0] n_sps, n_ps_o;
    logic [5:0]  n_cause;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .take_i(take), .pend_lvl_i(lvl), .pc_i(pc),
        .ps_i(ps), .int_set_i(iset), .int_en_i(ien), .taken_o(taken),
        .pc_we_o(pc_we), .pc_o(pc_o), .epc_we_o(epc_we), .eps_we_o(eps_we),
        .depc_we_o(depc_we), .save_pc_o(spc), .save_ps_o(sps), .ps_we_o(ps_we),
        .ps_o(ps_o), .cause_we_o(cause_we), .cause_o(cause)
    );

    irq_entry_seq #(.HAS_DEPC(1'b0)) dut_nd (
        .clk(clk), .rst_n(rst_n), .take_i(take), .pend_lvl_i(lvl), .pc_i(pc),
        .ps_i(ps), .int_set_i(iset), .int_en_i(ien), .taken_o(n_taken),
        .pc_we_o(n_pc_we), .pc_o(n_pc_o), .epc_we_o(n_epc_we), .eps_we_o(n_eps_we),
        .depc_we_o(n_depc_we), .save_pc_o(n_spc), .save_ps_o(n_sps), .ps_we_o(n_ps_we),
        .ps_o(n_ps_o), .cause_we_o(n_cause_we), .cause_o(n_cause)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (lvl=%0d ps=%h set=%h en=%h take=%0d)",
                     req, act, exp, lvl, ps, iset, ien, take);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        take = 0; lvl = 0; pc = 0; ps = 0; iset = 0; ien = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 taken", {63'd0, taken}, 64'd0);
        chk("R1 enables", {53'd0, pc_we, ps_we, cause_we, depc_we, epc_we, eps_we}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", {60'd0, taken, pc_we, ps_we, cause_we}, 64'd0);

        for (int lv = 0; lv < 8; lv++)
        for (int cur = 0; cur < 5; cur++)
        for (int md = 0; md < 4; md++)
        for (int pat = 0; pat < 6; pat++)
        for (int tk = 1; tk >= 0; tk--) begin
            bit          hit, acc;
            logic [7:0]  se;
            logic [31:0] e_pc;
            logic [15:0] e_ps, ps_in;
            logic [2:0]  e_epc, e_eps;
            logic        excm, um;
            string       rq;
            case (pat)
                0: begin iset = 8'hFF; ien = 8'hFF; end
                1: begin iset = 8'h01; ien = 8'hFF; end
                2: begin iset = 8'h02; ien = 8'hFF; end
                3: begin iset = 8'h04; ien = 8'hFF; end
                4: begin iset = 8'hFF; ien = 8'h00; end
                default: begin iset = 8'h48; ien = 8'h08; end
            endcase
            excm  = md[0];
            um    = md[1];
            ps_in = 16'hA500 | (16'(md) << 4) | 16'(cur);
            ps    = ps_in;
            lvl   = 3'(lv);
            take  = tk[0];
            pc    = pc + 32'h14;
            se    = iset & ien;
            hit   = 0;
            for (int i = 0; i < 8; i++)
                if (se[i] && ((i % NL) + 1) == lv) hit = 1;
            acc = tk[0] && hit && lv > cur && lv <= NL;

            e_epc = 0; e_eps = 0; e_pc = BASE; e_ps = ps_in;
            if (acc && lv > 1) begin
                e_pc  = BASE + 32'(lv) * 32'h100;
                e_ps  = (ps_in & 16'hFFF0) | 16'(lv) | 16'h0010;
                e_epc = 3'(1 << (lv - 1));
                e_eps = e_epc;
                rq = "R3";
            end else if (acc) begin
                e_ps = ps_in | 16'h0010;
                if (excm) begin e_pc = BASE + 32'hC0; rq = "R7"; end
                else begin
                    e_epc = 3'b001;
                    e_pc  = BASE + (um ? 32'h40 : 32'h80);
                    rq = "R8";
                end
            end else rq = tk[0] ? "R2" : "R11";

            @(posedge clk);
            @(negedge clk);
            // R10: outputs visible one cycle after the sampling edge
            chk({rq, " R10 taken"}, {63'd0, taken}, {63'd0, acc});
            chk({rq, " epc_we"}, {61'd0, epc_we}, {61'd0, e_epc});
            chk({rq, " eps_we"}, {61'd0, eps_we}, {61'd0, e_eps});
            chk({rq, " depc_we"}, {63'd0, depc_we}, {63'd0, acc && lv == 1 && excm});
            chk({rq, " cause_we"}, {63'd0, cause_we}, {63'd0, acc && lv == 1});
            if (acc) begin
                chk(lv > 1 ? "R5 pc" : {rq, " pc"}, {31'd0, pc_we, pc_o}, {31'd1, e_pc});
                chk(lv > 1 ? "R4 ps" : "R9 ps", {47'd0, ps_we, ps_o}, {47'd1, e_ps});
                chk({rq, " save_pc"}, {32'd0, spc}, {32'd0, pc});
                if (lv > 1) chk("R3 save_ps", {48'd0, sps}, {48'd0, ps_in});
                else        chk("R6 cause", {58'd0, cause}, 64'd4);
                if (lv == 1 && excm) begin
                    chk("R7 fallback epc", {61'd0, n_epc_we}, 64'd1);
                    chk("R7 fallback depc", {63'd0, n_depc_we}, 64'd0);
                end
            end else begin
                chk({rq, " quiet"}, {62'd0, pc_we, ps_we}, 64'd0);
                chk({rq, " quiet nd"}, {62'd0, n_taken, n_pc_we}, 64'd0);
            end
        end

        take = 0;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule